// File: doc/BRIEF.md
# Load/Store Ordering Queue with Store-to-Load Forwarding

This block keeps speculative loads and stores in their original program order while they execute out of order. It holds two circular queues, one for loads and one for stores, each eight entries deep. Every entry carries an allocation sequence number, and these numbers decide which operation is older. Addresses and store data arrive whenever address generation and operand delivery produce them.

When a load asks to issue, the block checks every older store. The load has to wait if any older store still lacks an address. It also waits if the youngest older store to the same address has no data yet. If that store does have its data, the data is forwarded to the load. If no older store matches, the load may read memory. When a store's address arrives, the block checks the loads that are younger than the store and have already completed. A match means a load read stale data, so the block reports that load for replay.

Stores write memory only when they commit from the head of the store queue, so memory sees them strictly in program order. A flush removes every entry that is younger than a given sequence number from both queues.

Top module: `lsq_top`

## Requirements
- R1: After reset both queues are empty: both alloc-ready outputs are 1, both alloc-slot outputs are 0, and violValid and memWrEn are 0. Each queue holds 8 entries. An allocation takes the slot shown on the alloc-slot output, and slots advance by one modulo 8. While a queue holds 8 entries its ready output is 0 and an allocation request is ignored.
- R2: A load issue request gives ldIssueRead=0 and ldIssueFwd=0 while any valid store that is older than the load has no address yet.
- R3: When every older store has an address and none of them matches the load's address, an eligible issue request gives ldIssueRead=1 and ldIssueFwd=0 in the same cycle.
- R4: When older stores match the load's address, only the youngest of them counts. If that store has data, the request gives ldIssueFwd=1, with ldFwdData equal to that store's data. If it has no data, both outputs are 0. Stores younger than the load never affect the result.
- R5: An issue request is eligible only for a valid load that has its address and has not completed. A forward or a read marks the load completed. A later request for the same load gives 0 on both outputs.
- R6: One cycle after a store address is filled, violValid is 1 if a valid load meets all of these: it is younger than the store, it has completed, and it has the same address. violLdSlot then gives the slot of the oldest such load. Otherwise violValid is 0.
- R7: A commit request retires the head store only if it has both address and data. memWrEn is 1 in that same cycle, with memWrAddr and memWrData equal to that store's address and data. Otherwise memWrEn is 0 and nothing changes. Stores therefore reach memory in allocation order.
- R8: A load retire request frees the head load only if that load has completed. Otherwise the request is ignored.
- R9: While flushValid is 1, every entry whose sequence number is younger than flushSeq is removed from both queues, and each tail rewinds to just past the last entry kept. All other requests in that cycle are ignored.
- R10: Sequence number a is older than b exactly when (a - b) mod 64 is 32 or more. This keeps ordering correct when the 6-bit numbers wrap around.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rstN | input | 1 | Active-low synchronous reset |
| ldAllocValid | input | 1 | Allocate a load entry |
| ldAllocSeq | input | 6 | Sequence number of the new load |
| ldAllocReady | output | 1 | Load queue has a free entry |
| ldAllocSlot | output | 3 | Slot the next load allocation takes |
| stAllocValid | input | 1 | Allocate a store entry |
| stAllocSeq | input | 6 | Sequence number of the new store |
| stAllocReady | output | 1 | Store queue has a free entry |
| stAllocSlot | output | 3 | Slot the next store allocation takes |
| ldAddrValid | input | 1 | Load address fill strobe |
| ldAddrSlot | input | 3 | Load slot being filled |
| ldAddr | input | 16 | Load effective address |
| stAddrValid | input | 1 | Store address fill strobe |
| stAddrSlot | input | 3 | Store slot being filled |
| stAddr | input | 16 | Store effective address |
| stDataValid | input | 1 | Store data fill strobe |
| stDataSlot | input | 3 | Store slot receiving data |
| stData | input | 32 | Store data |
| ldIssueValid | input | 1 | Load issue request |
| ldIssueSlot | input | 3 | Load slot asking to issue |
| ldIssueRead | output | 1 | Load may read memory |
| ldIssueFwd | output | 1 | Load is served by forwarding |
| ldFwdData | output | 32 | Forwarded store data |
| violValid | output | 1 | Ordering violation detected |
| violLdSlot | output | 3 | Slot of the load to replay |
| stCommitValid | input | 1 | Commit the head store |
| memWrEn | output | 1 | Memory write strobe |
| memWrAddr | output | 16 | Memory write address |
| memWrData | output | 32 | Memory write data |
| ldRetireValid | input | 1 | Retire the head load |
| flushValid | input | 1 | Flush younger entries |
| flushSeq | input | 6 | Youngest sequence number to keep |

## Verification
The bench aims at four kinds of case, each with its own failure:
- **Several older stores to one address.** A design that picked the oldest match would forward stale data. A design that ignored a younger match without data would forward a value that is not yet valid.
- **Younger stores to the same address.** These must not block a load or be forwarded to it.
- **A store address arriving after a younger load at that address has completed.** A design that missed this would raise no replay flag. A design that ignored completion status or age would flag the wrong load.
- **Sequence numbers that wrap around, queues that are full, and flushes that keep only part of a queue.** A design with a plain magnitude compare, or with a tail that fails to rewind, would forward to the wrong load or hand out the wrong slot on the next allocation.

// File: rtl/lsq_pkg.sv
package lsq_pkg;
  localparam int LQ_DEPTH_DEF = 8;
  localparam int SQ_DEPTH_DEF = 8;
  localparam int ADDR_W_DEF   = 16;
  localparam int DATA_W_DEF   = 32;
  localparam int SEQ_W_DEF    = 6;

  // write strobes from control to datapath storage
  typedef struct packed {
    logic ldAlloc;
    logic stAlloc;
    logic ldAddrWr;
    logic stAddrWr;
    logic stDataWr;
  } lsqStrobe_t;
endpackage

// File: rtl/lsq_data.sv
module lsq_data import lsq_pkg::*; #(
  parameter int LQ_DEPTH = LQ_DEPTH_DEF,
  parameter int SQ_DEPTH = SQ_DEPTH_DEF,
  parameter int ADDR_W   = ADDR_W_DEF,
  parameter int DATA_W   = DATA_W_DEF,
  parameter int SEQ_W    = SEQ_W_DEF,
  localparam int LQ_IW   = $clog2(LQ_DEPTH),
  localparam int SQ_IW   = $clog2(SQ_DEPTH)
) (
  input  logic                clk,
  input  logic                rstN,
  input  lsqStrobe_t          strobe,
  input  logic [LQ_IW-1:0]    ldTail,
  input  logic [SQ_IW-1:0]    stTail,
  input  logic [SQ_IW-1:0]    stHead,
  input  logic [SEQ_W-1:0]    ldAllocSeq,
  input  logic [SEQ_W-1:0]    stAllocSeq,
  input  logic [LQ_IW-1:0]    ldAddrSlot,
  input  logic [ADDR_W-1:0]   ldAddr,
  input  logic [SQ_IW-1:0]    stAddrSlot,
  input  logic [ADDR_W-1:0]   stAddr,
  input  logic [SQ_IW-1:0]    stDataSlot,
  input  logic [DATA_W-1:0]   stData,
  input  logic [LQ_IW-1:0]    ldIssueSlot,
  input  logic [SEQ_W-1:0]    flushSeq,
  input  logic [LQ_DEPTH-1:0] ldValid,
  input  logic [LQ_DEPTH-1:0] ldAddrV,
  input  logic [LQ_DEPTH-1:0] ldDone,
  input  logic [SQ_DEPTH-1:0] stValid,
  input  logic [SQ_DEPTH-1:0] stAddrV,
  input  logic [SQ_DEPTH-1:0] stDataV,
  output logic                olderUnknown,
  output logic                fwdHit,
  output logic                fwdHasData,
  output logic [DATA_W-1:0]   fwdData,
  output logic                violHit,
  output logic [LQ_IW-1:0]    violSlot,
  output logic [LQ_DEPTH-1:0] ldKeep,
  output logic [SQ_DEPTH-1:0] stKeep,
  output logic [ADDR_W-1:0]   headAddr,
  output logic [DATA_W-1:0]   headData
);
  // a is older than b when the wrapped difference is negative
  function automatic logic isOlder(input logic [SEQ_W-1:0] a, input logic [SEQ_W-1:0] b);
    logic [SEQ_W-1:0] diff;
    diff = a - b;
    return diff[SEQ_W-1];
  endfunction

  logic [SEQ_W-1:0]  ldSeqQ  [LQ_DEPTH];
  logic [ADDR_W-1:0] ldAddrQ [LQ_DEPTH];
  logic [SEQ_W-1:0]  stSeqQ  [SQ_DEPTH];
  logic [ADDR_W-1:0] stAddrQ [SQ_DEPTH];
  logic [DATA_W-1:0] stDataQ [SQ_DEPTH];

  always_ff @(posedge clk) begin
    if (strobe.ldAlloc)  ldSeqQ[ldTail]      <= ldAllocSeq;
    if (strobe.ldAddrWr) ldAddrQ[ldAddrSlot] <= ldAddr;
    if (strobe.stAlloc)  stSeqQ[stTail]      <= stAllocSeq;
    if (strobe.stAddrWr) stAddrQ[stAddrSlot] <= stAddr;
    if (strobe.stDataWr) stDataQ[stDataSlot] <= stData;
  end

  logic [SEQ_W-1:0]  probeSeq;
  logic [ADDR_W-1:0] probeAddr;
  logic [SEQ_W-1:0]  fillSeq;
  assign probeSeq  = ldSeqQ[ldIssueSlot];
  assign probeAddr = ldAddrQ[ldIssueSlot];
  assign fillSeq   = stSeqQ[stAddrSlot];

  logic [SQ_DEPTH-1:0] stOlder, stMatch, stUnknown;
  logic [LQ_DEPTH-1:0] ldHit;

  for (genvar i = 0; i < SQ_DEPTH; i++) begin : g_stCmp
    assign stOlder[i]   = stValid[i] && isOlder(stSeqQ[i], probeSeq);
    assign stMatch[i]   = stOlder[i] && stAddrV[i] && (stAddrQ[i] == probeAddr);
    assign stUnknown[i] = stOlder[i] && !stAddrV[i];
    assign stKeep[i]    = !isOlder(flushSeq, stSeqQ[i]);
  end

  for (genvar j = 0; j < LQ_DEPTH; j++) begin : g_ldCmp
    assign ldHit[j]  = ldValid[j] && ldAddrV[j] && ldDone[j] &&
                       (ldAddrQ[j] == stAddr) && isOlder(fillSeq, ldSeqQ[j]);
    assign ldKeep[j] = !isOlder(flushSeq, ldSeqQ[j]);
  end

  assign olderUnknown = |stUnknown;

  // youngest matching older store
  logic [SQ_IW-1:0] bestSt;
  logic             foundSt;
  always_comb begin
    bestSt  = '0;
    foundSt = 1'b0;
    for (int i = 0; i < SQ_DEPTH; i++) begin
      if (stMatch[i] && (!foundSt || isOlder(stSeqQ[bestSt], stSeqQ[i]))) begin
        foundSt = 1'b1;
        bestSt  = SQ_IW'(i);
      end
    end
  end
  assign fwdHit     = foundSt;
  assign fwdHasData = stDataV[bestSt];
  assign fwdData    = stDataQ[bestSt];

  // oldest completed younger load at the filled address
  logic [LQ_IW-1:0] bestLd;
  logic             foundLd;
  always_comb begin
    bestLd  = '0;
    foundLd = 1'b0;
    for (int j = 0; j < LQ_DEPTH; j++) begin
      if (ldHit[j] && (!foundLd || isOlder(ldSeqQ[j], ldSeqQ[bestLd]))) begin
        foundLd = 1'b1;
        bestLd  = LQ_IW'(j);
      end
    end
  end
  assign violHit  = foundLd;
  assign violSlot = bestLd;

  assign headAddr = stAddrQ[stHead];
  assign headData = stDataQ[stHead];

  // R7
  data_capture_chk: assert property (@(posedge clk) disable iff (!rstN)
    strobe.stDataWr |=> stDataQ[$past(stDataSlot)] == $past(stData));

  // R6
  viol_target_chk: assert property (@(posedge clk) disable iff (!rstN)
    violHit |-> ldDone[violSlot] && ldValid[violSlot]);
endmodule

// File: rtl/lsq_ctrl.sv
module lsq_ctrl import lsq_pkg::*; #(
  parameter int LQ_DEPTH = LQ_DEPTH_DEF,
  parameter int SQ_DEPTH = SQ_DEPTH_DEF,
  localparam int LQ_IW   = $clog2(LQ_DEPTH),
  localparam int SQ_IW   = $clog2(SQ_DEPTH)
) (
  input  logic                clk,
  input  logic                rstN,
  input  logic                ldAllocValid,
  input  logic                stAllocValid,
  input  logic                ldAddrValid,
  input  logic [LQ_IW-1:0]    ldAddrSlot,
  input  logic                stAddrValid,
  input  logic [SQ_IW-1:0]    stAddrSlot,
  input  logic                stDataValid,
  input  logic [SQ_IW-1:0]    stDataSlot,
  input  logic                ldIssueValid,
  input  logic [LQ_IW-1:0]    ldIssueSlot,
  input  logic                stCommitValid,
  input  logic                ldRetireValid,
  input  logic                flushValid,
  input  logic                olderUnknown,
  input  logic                fwdHit,
  input  logic                fwdHasData,
  input  logic                violHit,
  input  logic [LQ_IW-1:0]    violSlot,
  input  logic [LQ_DEPTH-1:0] ldKeep,
  input  logic [SQ_DEPTH-1:0] stKeep,
  output lsqStrobe_t          strobe,
  output logic [LQ_IW-1:0]    ldTail,
  output logic [SQ_IW-1:0]    stTail,
  output logic [SQ_IW-1:0]    stHead,
  output logic [LQ_DEPTH-1:0] ldValid,
  output logic [LQ_DEPTH-1:0] ldAddrV,
  output logic [LQ_DEPTH-1:0] ldDone,
  output logic [SQ_DEPTH-1:0] stValid,
  output logic [SQ_DEPTH-1:0] stAddrV,
  output logic [SQ_DEPTH-1:0] stDataV,
  output logic                ldAllocReady,
  output logic                stAllocReady,
  output logic                ldIssueRead,
  output logic                ldIssueFwd,
  output logic                violValid,
  output logic [LQ_IW-1:0]    violLdSlot,
  output logic                memWrEn
);
  logic [LQ_DEPTH-1:0] ldValidQ, ldAddrVQ, ldDoneQ;
  logic [SQ_DEPTH-1:0] stValidQ, stAddrVQ, stDataVQ;
  logic [LQ_IW-1:0]    ldHeadQ, ldTailQ;
  logic [SQ_IW-1:0]    stHeadQ, stTailQ;
  logic [LQ_IW:0]      ldCountQ;
  logic [SQ_IW:0]      stCountQ;
  logic                violValidQ;
  logic [LQ_IW-1:0]    violSlotQ;

  logic ldAllocFire, stAllocFire, ldAddrFire, stAddrFire, stDataFire;
  logic issueOk, ldRetireFire;
  logic [LQ_DEPTH-1:0] ldSurvive;
  logic [SQ_DEPTH-1:0] stSurvive;
  logic [LQ_IW:0]      ldSurviveCnt;
  logic [SQ_IW:0]      stSurviveCnt;

  assign ldAllocReady = (ldCountQ != LQ_DEPTH[LQ_IW:0]);
  assign stAllocReady = (stCountQ != SQ_DEPTH[SQ_IW:0]);

  assign ldAllocFire  = ldAllocValid && ldAllocReady && !flushValid;
  assign stAllocFire  = stAllocValid && stAllocReady && !flushValid;
  assign ldAddrFire   = ldAddrValid && ldValidQ[ldAddrSlot] && !flushValid;
  assign stAddrFire   = stAddrValid && stValidQ[stAddrSlot] && !flushValid;
  assign stDataFire   = stDataValid && stValidQ[stDataSlot] && !flushValid;

  assign issueOk      = ldIssueValid && ldValidQ[ldIssueSlot] && ldAddrVQ[ldIssueSlot] &&
                        !ldDoneQ[ldIssueSlot] && !flushValid && !olderUnknown;
  assign ldIssueRead  = issueOk && !fwdHit;
  assign ldIssueFwd   = issueOk && fwdHit && fwdHasData;

  assign ldRetireFire = ldRetireValid && ldValidQ[ldHeadQ] && ldDoneQ[ldHeadQ] && !flushValid;
  assign memWrEn      = stCommitValid && stValidQ[stHeadQ] && stAddrVQ[stHeadQ] &&
                        stDataVQ[stHeadQ] && !flushValid;

  assign ldSurvive    = ldValidQ & ldKeep;
  assign stSurvive    = stValidQ & stKeep;
  assign ldSurviveCnt = (LQ_IW+1)'($countones(ldSurvive));
  assign stSurviveCnt = (SQ_IW+1)'($countones(stSurvive));

  always_comb begin
    strobe          = '0;
    strobe.ldAlloc  = ldAllocFire;
    strobe.stAlloc  = stAllocFire;
    strobe.ldAddrWr = ldAddrFire;
    strobe.stAddrWr = stAddrFire;
    strobe.stDataWr = stDataFire;
  end

  // load queue state
  always_ff @(posedge clk) begin
    if (!rstN) begin
      ldValidQ <= '0;
      ldAddrVQ <= '0;
      ldDoneQ  <= '0;
      ldHeadQ  <= '0;
      ldTailQ  <= '0;
      ldCountQ <= '0;
    end else if (flushValid) begin
      ldValidQ <= ldSurvive;
      ldCountQ <= ldSurviveCnt;
      ldTailQ  <= ldHeadQ + ldSurviveCnt[LQ_IW-1:0];
    end else begin
      if (ldAllocFire) begin
        ldValidQ[ldTailQ] <= 1'b1;
        ldAddrVQ[ldTailQ] <= 1'b0;
        ldDoneQ[ldTailQ]  <= 1'b0;
        ldTailQ           <= ldTailQ + 1'b1;
      end
      if (ldAddrFire) ldAddrVQ[ldAddrSlot] <= 1'b1;
      if (ldIssueRead || ldIssueFwd) ldDoneQ[ldIssueSlot] <= 1'b1;
      if (ldRetireFire) begin
        ldValidQ[ldHeadQ] <= 1'b0;
        ldHeadQ           <= ldHeadQ + 1'b1;
      end
      ldCountQ <= ldCountQ + (LQ_IW+1)'(ldAllocFire) - (LQ_IW+1)'(ldRetireFire);
    end
  end

  // store queue state
  always_ff @(posedge clk) begin
    if (!rstN) begin
      stValidQ <= '0;
      stAddrVQ <= '0;
      stDataVQ <= '0;
      stHeadQ  <= '0;
      stTailQ  <= '0;
      stCountQ <= '0;
    end else if (flushValid) begin
      stValidQ <= stSurvive;
      stCountQ <= stSurviveCnt;
      stTailQ  <= stHeadQ + stSurviveCnt[SQ_IW-1:0];
    end else begin
      if (stAllocFire) begin
        stValidQ[stTailQ] <= 1'b1;
        stAddrVQ[stTailQ] <= 1'b0;
        stDataVQ[stTailQ] <= 1'b0;
        stTailQ           <= stTailQ + 1'b1;
      end
      if (stAddrFire) stAddrVQ[stAddrSlot] <= 1'b1;
      if (stDataFire) stDataVQ[stDataSlot] <= 1'b1;
      if (memWrEn) begin
        stValidQ[stHeadQ] <= 1'b0;
        stHeadQ           <= stHeadQ + 1'b1;
      end
      stCountQ <= stCountQ + (SQ_IW+1)'(stAllocFire) - (SQ_IW+1)'(memWrEn);
    end
  end

  // replay flag, one cycle after the store address arrives
  always_ff @(posedge clk) begin
    if (!rstN) begin
      violValidQ <= 1'b0;
      violSlotQ  <= '0;
    end else begin
      violValidQ <= stAddrFire && violHit;
      violSlotQ  <= violSlot;
    end
  end

  assign ldTail     = ldTailQ;
  assign stTail     = stTailQ;
  assign stHead     = stHeadQ;
  assign ldValid    = ldValidQ;
  assign ldAddrV    = ldAddrVQ;
  assign ldDone     = ldDoneQ;
  assign stValid    = stValidQ;
  assign stAddrV    = stAddrVQ;
  assign stDataV    = stDataVQ;
  assign violValid  = violValidQ;
  assign violLdSlot = violSlotQ;

  // R1
  ld_no_overflow_chk: assert property (@(posedge clk) disable iff (!rstN)
    ldCountQ <= LQ_DEPTH[LQ_IW:0]);
  // R1
  st_no_overflow_chk: assert property (@(posedge clk) disable iff (!rstN)
    stCountQ <= SQ_DEPTH[SQ_IW:0]);
  // R4
  read_fwd_excl_chk: assert property (@(posedge clk) disable iff (!rstN)
    !(ldIssueRead && ldIssueFwd));
  // R5
  issue_marks_done_chk: assert property (@(posedge clk) disable iff (!rstN)
    (ldIssueRead || ldIssueFwd) |=> ldDoneQ[$past(ldIssueSlot)]);
  // R6
  viol_after_fill_chk: assert property (@(posedge clk) disable iff (!rstN)
    violValidQ |-> $past(stAddrValid));
  // R7
  commit_pops_chk: assert property (@(posedge clk) disable iff (!rstN)
    (memWrEn && !stAllocFire) |=> stCountQ == $past(stCountQ) - 1'b1);
  // R9
  flush_shrinks_chk: assert property (@(posedge clk) disable iff (!rstN)
    flushValid |=> ldCountQ <= $past(ldCountQ) && stCountQ <= $past(stCountQ));
endmodule

// File: rtl/lsq_top.sv
module lsq_top import lsq_pkg::*; #(
  parameter int LQ_DEPTH = LQ_DEPTH_DEF,
  parameter int SQ_DEPTH = SQ_DEPTH_DEF,
  parameter int ADDR_W   = ADDR_W_DEF,
  parameter int DATA_W   = DATA_W_DEF,
  parameter int SEQ_W    = SEQ_W_DEF,
  localparam int LQ_IW   = $clog2(LQ_DEPTH),
  localparam int SQ_IW   = $clog2(SQ_DEPTH)
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              ldAllocValid,
  input  logic [SEQ_W-1:0]  ldAllocSeq,
  output logic              ldAllocReady,
  output logic [LQ_IW-1:0]  ldAllocSlot,
  input  logic              stAllocValid,
  input  logic [SEQ_W-1:0]  stAllocSeq,
  output logic              stAllocReady,
  output logic [SQ_IW-1:0]  stAllocSlot,
  input  logic              ldAddrValid,
  input  logic [LQ_IW-1:0]  ldAddrSlot,
  input  logic [ADDR_W-1:0] ldAddr,
  input  logic              stAddrValid,
  input  logic [SQ_IW-1:0]  stAddrSlot,
  input  logic [ADDR_W-1:0] stAddr,
  input  logic              stDataValid,
  input  logic [SQ_IW-1:0]  stDataSlot,
  input  logic [DATA_W-1:0] stData,
  input  logic              ldIssueValid,
  input  logic [LQ_IW-1:0]  ldIssueSlot,
  output logic              ldIssueRead,
  output logic              ldIssueFwd,
  output logic [DATA_W-1:0] ldFwdData,
  output logic              violValid,
  output logic [LQ_IW-1:0]  violLdSlot,
  input  logic              stCommitValid,
  output logic              memWrEn,
  output logic [ADDR_W-1:0] memWrAddr,
  output logic [DATA_W-1:0] memWrData,
  input  logic              ldRetireValid,
  input  logic              flushValid,
  input  logic [SEQ_W-1:0]  flushSeq
);
  lsqStrobe_t          strobe;
  logic [LQ_IW-1:0]    ldTail, violSlot;
  logic [SQ_IW-1:0]    stTail, stHead;
  logic [LQ_DEPTH-1:0] ldValid, ldAddrV, ldDone, ldKeep;
  logic [SQ_DEPTH-1:0] stValid, stAddrV, stDataV, stKeep;
  logic                olderUnknown, fwdHit, fwdHasData, violHit;

  assign ldAllocSlot = ldTail;
  assign stAllocSlot = stTail;

  lsq_ctrl #(.LQ_DEPTH(LQ_DEPTH), .SQ_DEPTH(SQ_DEPTH)) u_ctrl (
    .clk(clk), .rstN(rstN),
    .ldAllocValid(ldAllocValid), .stAllocValid(stAllocValid),
    .ldAddrValid(ldAddrValid), .ldAddrSlot(ldAddrSlot),
    .stAddrValid(stAddrValid), .stAddrSlot(stAddrSlot),
    .stDataValid(stDataValid), .stDataSlot(stDataSlot),
    .ldIssueValid(ldIssueValid), .ldIssueSlot(ldIssueSlot),
    .stCommitValid(stCommitValid), .ldRetireValid(ldRetireValid),
    .flushValid(flushValid),
    .olderUnknown(olderUnknown), .fwdHit(fwdHit), .fwdHasData(fwdHasData),
    .violHit(violHit), .violSlot(violSlot), .ldKeep(ldKeep), .stKeep(stKeep),
    .strobe(strobe), .ldTail(ldTail), .stTail(stTail), .stHead(stHead),
    .ldValid(ldValid), .ldAddrV(ldAddrV), .ldDone(ldDone),
    .stValid(stValid), .stAddrV(stAddrV), .stDataV(stDataV),
    .ldAllocReady(ldAllocReady), .stAllocReady(stAllocReady),
    .ldIssueRead(ldIssueRead), .ldIssueFwd(ldIssueFwd),
    .violValid(violValid), .violLdSlot(violLdSlot), .memWrEn(memWrEn)
  );

  lsq_data #(.LQ_DEPTH(LQ_DEPTH), .SQ_DEPTH(SQ_DEPTH), .ADDR_W(ADDR_W),
             .DATA_W(DATA_W), .SEQ_W(SEQ_W)) u_data (
    .clk(clk), .rstN(rstN), .strobe(strobe),
    .ldTail(ldTail), .stTail(stTail), .stHead(stHead),
    .ldAllocSeq(ldAllocSeq), .stAllocSeq(stAllocSeq),
    .ldAddrSlot(ldAddrSlot), .ldAddr(ldAddr),
    .stAddrSlot(stAddrSlot), .stAddr(stAddr),
    .stDataSlot(stDataSlot), .stData(stData),
    .ldIssueSlot(ldIssueSlot), .flushSeq(flushSeq),
    .ldValid(ldValid), .ldAddrV(ldAddrV), .ldDone(ldDone),
    .stValid(stValid), .stAddrV(stAddrV), .stDataV(stDataV),
    .olderUnknown(olderUnknown), .fwdHit(fwdHit), .fwdHasData(fwdHasData),
    .fwdData(ldFwdData), .violHit(violHit), .violSlot(violSlot),
    .ldKeep(ldKeep), .stKeep(stKeep),
    .headAddr(memWrAddr), .headData(memWrData)
  );
endmodule

// File: tb/sim_lsq_top.sv
module sim_lsq_top;
  localparam int D = 8;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        ldAllocValid = 0, stAllocValid = 0;
  logic [5:0]  ldAllocSeq = 0, stAllocSeq = 0;
  logic        ldAllocReady, stAllocReady;
  logic [2:0]  ldAllocSlot, stAllocSlot;
  logic        ldAddrValid = 0, stAddrValid = 0, stDataValid = 0;
  logic [2:0]  ldAddrSlot = 0, stAddrSlot = 0, stDataSlot = 0;
  logic [15:0] ldAddr = 0, stAddr = 0;
  logic [31:0] stData = 0;
  logic        ldIssueValid = 0;
  logic [2:0]  ldIssueSlot = 0;
  logic        ldIssueRead, ldIssueFwd;
  logic [31:0] ldFwdData;
  logic        violValid;
  logic [2:0]  violLdSlot;
  logic        stCommitValid = 0, memWrEn;
  logic [15:0] memWrAddr;
  logic [31:0] memWrData;
  logic        ldRetireValid = 0, flushValid = 0;
  logic [5:0]  flushSeq = 0;

  lsq_top u0 (.*);

  always #5 clk = ~clk;

  // bench-side model
  bit          mLdV[D], mLdAV[D], mLdDone[D];
  logic [5:0]  mLdSeq[D];
  logic [15:0] mLdAddr[D];
  bit          mStV[D], mStAV[D], mStDV[D];
  logic [5:0]  mStSeq[D];
  logic [15:0] mStAddr[D];
  logic [31:0] mStData[D];
  int mLdHead = 0, mLdCnt = 0, mStHead = 0, mStCnt = 0;
  int nextSeq = 0;
  int errors = 0, checks = 0;
  bit finished = 0;

  function automatic bit older(logic [5:0] a, logic [5:0] b);
    logic [5:0] d;
    d = a - b;
    return d[5];
  endfunction

  task automatic check(string req, logic [63:0] act, logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic checkAlloc(string req);
    check(req, ldAllocReady, mLdCnt < D);
    check(req, ldAllocSlot, (mLdHead + mLdCnt) % D);
    check(req, stAllocReady, mStCnt < D);
    check(req, stAllocSlot, (mStHead + mStCnt) % D);
  endtask

  task automatic opAllocLd();
    @(negedge clk); ldAllocValid = 1; ldAllocSeq = nextSeq[5:0];
    #2 checkAlloc("R1");
    @(posedge clk); #1 ldAllocValid = 0;
    if (mLdCnt < D) begin
      int t = (mLdHead + mLdCnt) % D;
      mLdV[t] = 1; mLdAV[t] = 0; mLdDone[t] = 0; mLdSeq[t] = nextSeq[5:0];
      mLdCnt++; nextSeq = (nextSeq + 1) % 64;
    end
  endtask

  task automatic opAllocSt();
    @(negedge clk); stAllocValid = 1; stAllocSeq = nextSeq[5:0];
    #2 checkAlloc("R1");
    @(posedge clk); #1 stAllocValid = 0;
    if (mStCnt < D) begin
      int t = (mStHead + mStCnt) % D;
      mStV[t] = 1; mStAV[t] = 0; mStDV[t] = 0; mStSeq[t] = nextSeq[5:0];
      mStCnt++; nextSeq = (nextSeq + 1) % 64;
    end
  endtask

  task automatic opLdAddr(int s, logic [15:0] a);
    @(negedge clk); ldAddrValid = 1; ldAddrSlot = 3'(s); ldAddr = a;
    @(posedge clk); #1 ldAddrValid = 0;
    if (mLdV[s]) begin mLdAV[s] = 1; mLdAddr[s] = a; end
  endtask

  task automatic opStData(int s, logic [31:0] v);
    @(negedge clk); stDataValid = 1; stDataSlot = 3'(s); stData = v;
    @(posedge clk); #1 stDataValid = 0;
    if (mStV[s]) begin mStDV[s] = 1; mStData[s] = v; end
  endtask

  task automatic opStAddr(int s, logic [15:0] a);
    bit eHit = 0;
    int eSlot = 0;
    if (mStV[s]) begin
      for (int j = 0; j < D; j++)
        if (mLdV[j] && mLdAV[j] && mLdDone[j] && mLdAddr[j] == a && older(mStSeq[s], mLdSeq[j]) &&
            (!eHit || older(mLdSeq[j], mLdSeq[eSlot]))) begin
          eHit = 1; eSlot = j;
        end
    end
    @(negedge clk); stAddrValid = 1; stAddrSlot = 3'(s); stAddr = a;
    @(posedge clk); #1 stAddrValid = 0;
    check("R6", violValid, eHit);
    if (eHit) check("R6", violLdSlot, eSlot);
    if (mStV[s]) begin mStAV[s] = 1; mStAddr[s] = a; end
  endtask

  task automatic opIssue(int s, string tagIn);
    bit eRead = 0, eFwd = 0, unknown = 0, found = 0;
    int best = 0;
    string tag = "R5";
    logic [31:0] eData = 0;
    if (mLdV[s] && mLdAV[s] && !mLdDone[s]) begin
      for (int i = 0; i < D; i++) begin
        if (mStV[i] && older(mStSeq[i], mLdSeq[s])) begin
          if (!mStAV[i]) unknown = 1;
          else if (mStAddr[i] == mLdAddr[s] && (!found || older(mStSeq[best], mStSeq[i]))) begin
            found = 1; best = i;
          end
        end
      end
      if (unknown) tag = "R2";
      else if (found) begin tag = "R4"; eFwd = mStDV[best]; eData = mStData[best]; end
      else begin tag = "R3"; eRead = 1; end
    end
    if (tagIn != "") tag = tagIn;
    @(negedge clk); ldIssueValid = 1; ldIssueSlot = 3'(s);
    #2;
    check(tag, ldIssueRead, eRead);
    check(tag, ldIssueFwd, eFwd);
    if (eFwd) check(tag, ldFwdData, eData);
    @(posedge clk); #1 ldIssueValid = 0;
    if (eRead || eFwd) mLdDone[s] = 1;
  endtask

  task automatic opCommit();
    bit en = mStCnt > 0 && mStV[mStHead] && mStAV[mStHead] && mStDV[mStHead];
    @(negedge clk); stCommitValid = 1;
    #2;
    check("R7", memWrEn, en);
    if (en) begin
      check("R7", memWrAddr, mStAddr[mStHead]);
      check("R7", memWrData, mStData[mStHead]);
    end
    @(posedge clk); #1 stCommitValid = 0;
    if (en) begin mStV[mStHead] = 0; mStHead = (mStHead + 1) % D; mStCnt--; end
  endtask

  task automatic opRetire();
    @(negedge clk); ldRetireValid = 1;
    @(posedge clk); #1 ldRetireValid = 0;
    if (mLdCnt > 0 && mLdV[mLdHead] && mLdDone[mLdHead]) begin
      mLdV[mLdHead] = 0; mLdHead = (mLdHead + 1) % D; mLdCnt--;
    end
    checkAlloc("R8");
  endtask

  task automatic opFlush(logic [5:0] fs);
    int c;
    @(negedge clk); flushValid = 1; flushSeq = fs;
    ldAllocValid = 1; stAllocValid = 1; ldAllocSeq = 6'h3f; stAllocSeq = 6'h3f;
    @(posedge clk); #1 flushValid = 0; ldAllocValid = 0; stAllocValid = 0;
    c = 0;
    for (int i = 0; i < D; i++) begin
      if (mLdV[i] && older(fs, mLdSeq[i])) mLdV[i] = 0;
      if (mLdV[i]) c++;
    end
    mLdCnt = c;
    c = 0;
    for (int i = 0; i < D; i++) begin
      if (mStV[i] && older(fs, mStSeq[i])) mStV[i] = 0;
      if (mStV[i]) c++;
    end
    mStCnt = c;
    nextSeq = (int'(fs) + 1) % 64;
    checkAlloc("R9");
  endtask

  task automatic flushAll();
    logic [5:0] oldest = nextSeq[5:0];
    for (int i = 0; i < D; i++) begin
      if (mLdV[i] && older(mLdSeq[i], oldest)) oldest = mLdSeq[i];
      if (mStV[i] && older(mStSeq[i], oldest)) oldest = mStSeq[i];
    end
    opFlush(oldest - 6'd1);
  endtask

  // watchdog
  initial begin
    #(200000 * 10);
    if (!finished) begin
      errors++; checks++;
      $display("FAIL watchdog: actual=timeout expected=done");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd20240611));
    repeat (3) @(posedge clk);
    #1 rstN = 1;
    @(negedge clk);
    checkAlloc("R1");
    check("R1", violValid, 0);
    check("R1", memWrEn, 0);

    // forwarding, blocking, violation
    opAllocSt(); opAllocSt(); opAllocLd(); opAllocSt();
    opLdAddr(0, 16'h10);
    opIssue(0, "R2");
    opStAddr(0, 16'h10); opStData(0, 32'h11);
    opStAddr(1, 16'h10);
    opIssue(0, "R4");
    opStData(1, 32'h22);
    opIssue(0, "R4");
    opIssue(0, "R5");
    opStAddr(2, 16'h10);
    opAllocLd(); opLdAddr(1, 16'h30); opIssue(1, "R3");
    opCommit(); opCommit(); opCommit();
    opFlush(nextSeq[5:0] - 6'd3);
    opRetire();
    flushAll();

    // full load queue
    for (int i = 0; i < D + 1; i++) opAllocLd();
    opRetire();
    flushAll();

    // sequence wraparound
    nextSeq = 63;
    opAllocSt(); opAllocLd(); opAllocSt();
    opStAddr(mStHead, 16'h50); opStData(mStHead, 32'h77);
    opStAddr((mStHead + 1) % D, 16'h50);
    opLdAddr(mLdHead, 16'h50);
    opIssue(mLdHead, "R10");
    opCommit(); opRetire();
    flushAll();

    // constrained random
    for (int n = 0; n < 4000; n++) begin
      int op = $urandom % 100;
      int s = $urandom % D;
      logic [15:0] a = 16'h40 + 16'($urandom % 4);
      if (op < 12) opAllocLd();
      else if (op < 24) opAllocSt();
      else if (op < 36) opLdAddr(s, a);
      else if (op < 48) opStAddr(s, a);
      else if (op < 58) opStData(s, $urandom);
      else if (op < 78) opIssue(s, "");
      else if (op < 87) opCommit();
      else if (op < 97) opRetire();
      else begin
        int k = $urandom % D;
        if (mStV[k]) opFlush(mStSeq[k]);
        else if (mLdV[k]) opFlush(mLdSeq[k]);
        else opFlush(nextSeq[5:0] - 6'd1);
      end
    end

    finished = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule